// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave port that gives a host read and write access to a small bank of byte-wide configuration registers. The host frames each transaction by pulling an active-low select line low, and then clocks an 8-bit command followed by one to four data bytes over a serial clock. While select is high the port sits idle, and it starts every new frame with a fresh command. All serial inputs are resynchronised to a local system clock, which must run at least eight times faster than the serial clock.

Read data leaves the port on one of two pins. By default the shared data pin is only an input and read data goes out on a separate output pin, which gives a four-wire bus. When the direction bit in register 0 is set, read data goes back out on the shared data pin instead, and the separate output pin is released, which gives a three-wire bus. Output enables stand in for tri-state control. A hardware reset puts every register back to its default. A self-clearing bit in register 0 does the same for every register except register 0.

Top module: `spi_regport`

## Requirements
- R1: Input bits are taken on the rising edge of the serial clock, MSB first. The command byte is bit 7 = read (1) or write (0), bits 6:5 = byte count minus one, and bits 4:0 = start address. Each whole write byte is stored at its current address.
- R2: Read data is driven only after falling edges of the serial clock, MSB first. The first bit appears after the falling edge that follows the eighth command bit.
- R3: A command transfers exactly count+1 bytes. The address increases by one after each byte and wraps from 31 to 0. Bits clocked after the last byte, before select goes high, have no effect.
- R4: When register 0 bit 7 is 0, read data leaves on `sdo_o` with `sdo_oe`=1 and `sdio_oe`=0. When it is 1, read data leaves on `sdio_o` with `sdio_oe`=1 and `sdo_oe`=0. The two enables are never both 1.
- R5: Select high aborts any frame in progress, drops both output enables and blocks writes. The next frame starts with a new command byte.
- R6: Hardware reset (`rst_n`=0 at a clock edge) sets register 0 to 0x00 and every other register k to (17·k) mod 256.
- R7: Writing register 0 with bit 5 set returns registers 1 to NUM_REGS-1 to their R6 defaults. Register 0 takes the written value, and bit 5 always reads back as 0.
- R8: Addresses at or above NUM_REGS (default 8) ignore writes and read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| spi_csn | input | 1 | Frame select, active low; high idles and resynchronises the port |
| spi_sclk | input | 1 | Serial clock, idle low |
| sdio_i | input | 1 | Shared data pin, input side |
| sdio_o | output | 1 | Shared data pin, output side |
| sdio_oe | output | 1 | Shared data pin output enable |
| sdo_o | output | 1 | Separate read data output |
| sdo_oe | output | 1 | Separate read data output enable (0 = high impedance) |

## Verification
The bound checker watches, on every cycle, the properties that hold at any instant. It checks that the two output enables never overlap, that read data moves only after a serial falling edge or a select-high, and that select high releases the pins and blocks writes. It also checks that a write or a soft reset lands in the bank one cycle later and that unmapped writes leave the bank untouched. Only the bench's frame-level scenarios can show the end-to-end behaviour. These cover the command decoding, burst counts with address wrap, the trailing bits that are ignored, aborted frames, the direction switch, and the default values after each kind of reset, all compared against a register model written from the requirements.

// File: rtl/spi_regport_pkg.sv
// Package: shared types and constants for the serial register port.
// Assumes byte-wide registers and a 5-bit register address space.
package spi_regport_pkg;

    localparam int ADDR_W   = 5;
    localparam int BYTE_W   = 8;
    localparam int MODE_BIT = 7;   // register 0: 1 = read data on shared pin
    localparam int SRST_BIT = 5;   // register 0: write 1 = soft reset

    // Frame phase of the serial engine
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    // Power-on value of register k (register 0 resolves to zero)
    function automatic logic [BYTE_W-1:0] reg_default(input int k);
        return BYTE_W'(k * 17);
    endfunction

endpackage

// File: rtl/spi_sync.sv
// Module: multi-bit input synchroniser.
// Each bit passes through its own chain of STAGES flops into the clk domain.
// Assumes the bits are independent levels sampled well above their toggle rate.
module spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw level through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[g]};
            end
        end

        assign dout[g] = chain[LAST];
    end

endmodule

// File: rtl/spi_edge_det.sv
// Module: single-bit edge detector.
// Flags one-cycle rise/fall pulses of an already synchronised level.
// Assumes the level idles low out of reset.
module spi_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic level_q;

    // Remember the previous sample of the level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;

endmodule

// File: rtl/spi_frame_engine.sv
// Module: serial frame decoder.
// Collects the command byte, tracks the byte count and auto-increments the
// address. It emits one write strobe per received byte and shifts read data
// out on serial falling edges. Assumes rise/fall pulses are single-cycle and
// never coincide, and that rdata follows addr combinationally.
module spi_frame_engine
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    input  logic              bidir,
    input  logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wdata,
    output logic              out_bit,
    output logic              sdio_oe,
    output logic              sdo_oe
);

    localparam int CNT_W = $clog2(BYTE_W);

    phase_t             phase;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-2:0]  shreg;
    logic [1:0]         bytes_left;
    logic               is_rd;
    logic [BYTE_W-1:0]  next_byte;
    logic               byte_end;
    logic               rd_drive;

    // Byte as it stands once the current input bit is appended
    always_comb begin
        next_byte = {shreg, sdi};
        byte_end  = (bit_cnt == CNT_W'(BYTE_W - 1));
    end

    // Frame state: command decode, byte counting, address stepping
    always_ff @(posedge clk) begin
        if (!rst_n || cs_hi) begin
            phase      <= PH_CMD;
            bit_cnt    <= '0;
            shreg      <= '0;
            bytes_left <= '0;
            is_rd      <= 1'b0;
            addr       <= '0;
        end else if (sck_rise) begin
            case (phase)
                PH_CMD: begin
                    shreg   <= next_byte[BYTE_W-2:0];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (byte_end) begin
                        is_rd      <= next_byte[7];
                        bytes_left <= next_byte[6:5];
                        addr       <= next_byte[ADDR_W-1:0];
                        phase      <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    shreg   <= next_byte[BYTE_W-2:0];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (byte_end) begin
                        addr <= addr + 1'b1;
                        if (bytes_left == 2'd0) begin
                            phase <= PH_DONE;
                        end else begin
                            bytes_left <= bytes_left - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Read shifter: present the next MSB-first bit after each falling edge
    always_ff @(posedge clk) begin
        if (!rst_n || cs_hi) begin
            out_bit <= 1'b0;
        end else if (sck_fall && phase == PH_DATA && is_rd) begin
            out_bit <= rdata[~bit_cnt];
        end
    end

    // Write strobe and pin direction
    always_comb begin
        wr_en    = sck_rise && (phase == PH_DATA) && !is_rd && byte_end;
        wdata    = next_byte;
        rd_drive = (phase == PH_DATA) && is_rd;
        sdio_oe  = rd_drive && bidir;
        sdo_oe   = rd_drive && !bidir;
    end

endmodule

// File: rtl/spi_reg_bank.sv
// Module: configuration register bank.
// Holds NUM_REGS byte registers, hardware reset to reg_default(k). Register 0
// carries the pin-direction bit and a soft-reset bit that never stores;
// writing it returns registers 1..NUM_REGS-1 to their defaults.
// Assumes at most one write per cycle.
module spi_reg_bank
    import spi_regport_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [BYTE_W-1:0]          wdata,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat,
    output logic                       bidir
);

    localparam logic [BYTE_W-1:0] SRST_MASK = BYTE_W'(1) << SRST_BIT;

    logic soft_rst;

    // Soft reset fires on the same cycle as the register-0 write carrying it
    always_comb begin
        soft_rst = wr_en && (waddr == '0) && wdata[SRST_BIT];
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        logic [BYTE_W-1:0] val;

        if (k == 0) begin : g_ctrl
            // Control register: write stores all but the self-clearing bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val <= reg_default(0);
                end else if (wr_en && waddr == '0) begin
                    val <= wdata & ~SRST_MASK;
                end
            end
        end else begin : g_data
            // Data register: write, else soft reset to default
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val <= reg_default(k);
                end else if (wr_en && waddr == ADDR_W'(k)) begin
                    val <= wdata;
                end else if (soft_rst) begin
                    val <= reg_default(k);
                end
            end
        end

        assign regs_flat[k*BYTE_W +: BYTE_W] = val;
    end

    assign bidir = regs_flat[MODE_BIT];

endmodule

// File: rtl/spi_regport.sv
// Module: top of the serial configuration register port.
// Synchronises select, serial clock and data into clk, decodes frames and
// serves the register bank. Assumes clk runs at least 8x the serial clock
// and that NUM_REGS is in 2..32.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_csn,
    input  logic spi_sclk,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe,
    output logic sdo_o,
    output logic sdo_oe
);

    localparam int FLAT_W = NUM_REGS * BYTE_W;
    localparam logic [2:0] SYNC_RST = 3'b100;   // select idles high

    logic [2:0]          sync_q;
    logic                cs_hi;
    logic                sck_lvl;
    logic                sdi;
    logic                sck_rise;
    logic                sck_fall;
    logic [ADDR_W-1:0]   addr;
    logic                wr_en;
    logic [BYTE_W-1:0]   wdata;
    logic [BYTE_W-1:0]   rdata;
    logic [FLAT_W-1:0]   regs_flat;
    logic                bidir;
    logic                out_bit;

    spi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_csn, spi_sclk, sdio_i}),
        .dout  (sync_q)
    );

    assign cs_hi   = sync_q[2];
    assign sck_lvl = sync_q[1];
    assign sdi     = sync_q[0];

    spi_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sck_lvl),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    spi_frame_engine u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_hi    (cs_hi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi      (sdi),
        .bidir    (bidir),
        .rdata    (rdata),
        .addr     (addr),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .out_bit  (out_bit),
        .sdio_oe  (sdio_oe),
        .sdo_oe   (sdo_oe)
    );

    spi_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .waddr     (addr),
        .wdata     (wdata),
        .regs_flat (regs_flat),
        .bidir     (bidir)
    );

    // Read mux: unmapped addresses return zero
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (addr == ADDR_W'(k)) begin
                rdata = regs_flat[k*BYTE_W +: BYTE_W];
            end
        end
    end

    assign sdio_o = out_bit;
    assign sdo_o  = out_bit;

endmodule

// File: rtl/spi_regport_chk.sv
// Module: property checker bound into spi_regport.
// Watches pin enables, read-bit timing, write landing and both resets.
module spi_regport_chk
    import spi_regport_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cs_hi,
    input logic                       sck_fall,
    input logic                       sdio_oe,
    input logic                       sdo_oe,
    input logic                       out_bit,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [BYTE_W-1:0]          wdata,
    input logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

    localparam int TOP_LSB = (NUM_REGS - 1) * BYTE_W;

    assert_single_driver_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));

    assert_release_on_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !(sdio_oe || sdo_oe));

    assert_no_write_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !cs_hi);

    assert_bit_moves_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_bit) |-> $past(sck_fall || cs_hi));

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1)) |=> (regs_flat[2*BYTE_W-1:BYTE_W] == $past(wdata)));

    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wdata[SRST_BIT])
            |=> (regs_flat[TOP_LSB +: BYTE_W] == reg_default(NUM_REGS - 1))
                && !regs_flat[SRST_BIT]
                && (regs_flat[MODE_BIT] == $past(wdata[MODE_BIT])));

    assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && 32'(addr) >= 32'(NUM_REGS)) |=> $stable(regs_flat));

    assert_hw_reset_R6: assert property (@(posedge clk)
        !rst_n |=> (regs_flat[BYTE_W-1:0] == reg_default(0)));

endmodule

bind spi_regport spi_regport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_hi     (cs_hi),
    .sck_fall  (sck_fall),
    .sdio_oe   (sdio_oe),
    .sdo_oe    (sdo_oe),
    .out_bit   (out_bit),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .regs_flat (regs_flat)
);

// File: tb/sim_spi_regport.sv
// Bench: drives serial frames at 1/16 of clk and compares every byte read
// back against a register model built from the requirements.
module sim_spi_regport;

    localparam int HP   = 8;    // clk cycles per serial half period
    localparam int NREG = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;      // 50 MHz

    logic rst_n    = 1'b0;
    logic spi_csn  = 1'b1;
    logic spi_sclk = 1'b0;
    logic sdio_i   = 1'b0;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    bit   oe_bad = 1'b0;
    logic [7:0]  model [32];
    logic [31:0] rq;

    spi_regport #(.NUM_REGS(NREG)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_csn  (spi_csn),
        .spi_sclk (spi_sclk),
        .sdio_i   (sdio_i),
        .sdio_o   (sdio_o),
        .sdio_oe  (sdio_oe),
        .sdo_o    (sdo_o),
        .sdo_oe   (sdo_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R6 defaults: reg0 = 0, reg k = 17k
    task automatic model_reset();
        for (int k = 0; k < 32; k++) model[k] = (k < NREG) ? 8'(k * 17) : 8'h00;
    endtask

    // R1/R7/R8 write model
    task automatic model_write(input int a, input logic [7:0] d);
        if (a < NREG) begin
            if (a == 0) begin
                model[0] = d & 8'hDF;
                if (d[5]) for (int k = 1; k < NREG; k++) model[k] = 8'(k * 17);
            end else begin
                model[a] = d;
            end
        end
    endtask

    // One serial bit: set data, rise after HP, fall after another HP
    task automatic shift_bit(input logic b, input bit want_rd, input bit via_sdio, output logic got);
        sdio_i = b;
        repeat (HP) @(negedge clk);
        got = via_sdio ? sdio_o : sdo_o;
        if (want_rd && (via_sdio ? !(sdio_oe && !sdo_oe) : !(sdo_oe && !sdio_oe))) oe_bad = 1'b1;
        spi_sclk = 1'b1;
        repeat (HP) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic xfer(input bit rd, input int nb, input int addr, input logic [31:0] wd,
                        input bit via_sdio, output logic [31:0] rdq);
        logic [7:0] cmd;
        logic       g;
        cmd    = {rd, 2'(nb - 1), 5'(addr)};
        rdq    = '0;
        oe_bad = 1'b0;
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 7; i >= 0; i--) shift_bit(cmd[i], 1'b0, via_sdio, g);
        for (int b = 0; b < nb; b++) begin
            for (int i = 7; i >= 0; i--) begin
                shift_bit(rd ? 1'b0 : wd[24 - 8*b + i], rd, via_sdio, g);
                rdq[24 - 8*b + i] = g;
            end
        end
        repeat (HP) @(negedge clk);
        spi_csn = 1'b1;
        repeat (2*HP) @(negedge clk);
        if (!rd) for (int b = 0; b < nb; b++) model_write((addr + b) % 32, wd[24 - 8*b +: 8]);
    endtask

    task automatic rd_check(input string tag, input int addr, input int nb, input bit via_sdio);
        xfer(1'b1, nb, addr, 32'h0, via_sdio, rq);
        for (int b = 0; b < nb; b++) chk(tag, rq[24 - 8*b +: 8], model[(addr + b) % 32]);
        chk({tag, " R4 enables"}, oe_bad, 1'b0);
    endtask

    task automatic wr(input int addr, input int nb, input logic [31:0] wd);
        xfer(1'b0, nb, addr, wd, 1'b0, rq);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic g;
        model_reset();
        repeat (4) @(negedge clk);
        chk("R5 enables in reset", {30'b0, sdio_oe, sdo_oe}, 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6 defaults and R8 unmapped reads
        rd_check("R6 defaults lo", 0, 4, 1'b0);
        rd_check("R6 defaults hi", 4, 4, 1'b0);
        rd_check("R8 unmapped read", 8, 4, 1'b0);

        // R1/R3 burst writes, R8 writes past the bank
        wr(1, 4, {8'h3C, 8'hA5, 8'h96, 8'h01});
        wr(5, 3, {8'h5E, 8'hE7, 8'h7B, 8'h00});
        wr(8, 4, 32'hFFFF_FFFF);
        wr(30, 4, {8'hAA, 8'hBB, 8'h41, 8'hC8});   // wraps into reg0, reg1
        rd_check("R1 R8 after writes", 0, 2, 1'b0);

        // R2/R3: every start address with a 4-byte burst, wrap included
        for (int a = 0; a < 32; a++) rd_check("R2 R3 sweep", a, 4, 1'b0);
        for (int n = 1; n <= 4; n++) rd_check("R3 count", 2, n, 1'b0);

        // R5: abort a write mid-byte; register must keep its value
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 7; i >= 0; i--) shift_bit(((8'h02 >> i) & 8'h01) != 0, 1'b0, 1'b0, g);
        for (int i = 0; i < 5; i++) shift_bit(1'b1, 1'b0, 1'b0, g);
        spi_csn = 1'b1;
        repeat (2*HP) @(negedge clk);
        rd_check("R5 aborted write", 2, 1, 1'b0);

        // R5: abort a read mid-byte, pins must release
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 7; i >= 0; i--) shift_bit(((8'h83 >> i) & 8'h01) != 0, 1'b0, 1'b0, g);
        for (int i = 0; i < 3; i++) shift_bit(1'b0, 1'b0, 1'b0, g);
        spi_csn = 1'b1;
        repeat (2*HP) @(negedge clk);
        chk("R5 release after abort", {30'b0, sdio_oe, sdo_oe}, 32'h0);
        wr(3, 1, {8'h5A, 24'h0});
        rd_check("R5 new frame after abort", 3, 1, 1'b0);

        // R3: bits after the last byte are ignored (reg4 untouched)
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 7; i >= 0; i--) shift_bit(((8'h03 >> i) & 8'h01) != 0, 1'b0, 1'b0, g);
        for (int i = 7; i >= 0; i--) shift_bit(((8'h77 >> i) & 8'h01) != 0, 1'b0, 1'b0, g);
        for (int i = 0; i < 8; i++) shift_bit(1'b1, 1'b0, 1'b0, g);
        spi_csn = 1'b1;
        repeat (2*HP) @(negedge clk);
        model_write(3, 8'h77);
        rd_check("R3 trailing bits", 3, 2, 1'b0);

        // R4: three-wire mode, read data on the shared pin
        wr(0, 1, {8'h80, 24'h0});
        rd_check("R4 shared pin read", 0, 4, 1'b1);
        wr(6, 1, {8'hC3, 24'h0});
        rd_check("R4 shared pin read hi", 4, 4, 1'b1);

        // R7: soft reset keeps reg0 (bit 5 reads 0), restores the rest
        wr(0, 1, {8'hA4, 24'h0});
        rd_check("R7 soft reset lo", 0, 4, 1'b1);
        rd_check("R7 soft reset hi", 4, 4, 1'b1);
        wr(0, 2, {8'h20, 8'h99, 16'h0});
        rd_check("R7 soft reset then write", 0, 2, 1'b0);

        // R6: hardware reset restores reg0 too
        wr(0, 1, {8'h80, 24'h0});
        xfer(1'b0, 1, 2, {8'h12, 24'h0}, 1'b1, rq);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        repeat (4) @(negedge clk);
        rd_check("R6 hardware reset lo", 0, 4, 1'b0);
        rd_check("R6 hardware reset hi", 4, 4, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule